// File: doc/BRIEF.md
# Parallel Flash Device Identification Sequencer

This block is the master side of an 8-bit parallel NOR flash port. After a one-cycle start pulse it finds out which device is attached by using the standard autoselect command exchange. First it waits for the bus to go quiet by reading location 0 until two reads in a row agree. It then sends a reset command and the three-write unlock sequence that enters identification mode. It reads the manufacturer and device bytes, checks them, and always ends by sending the reset command again so the device is back in array-read mode.

The two ID bytes must each have odd parity. If they do, they are joined into a 16-bit key and looked up in a small built-in table. The table gives the device size and the sector size, both as log2 of the byte count. When the probe ends, the block raises a one-cycle done pulse. The found flag, the raw ID bytes and the sizes then stay valid until the next accepted start. Each bus access takes a fixed number of clock cycles, set by a parameter.

Top module: `flash_id_probe`

## Requirements
- R1: After reset, busy_o, done_o, found_o, fl_we_o and fl_oe_o are 0, and mfr_o, dev_o and both size outputs are 0.
- R2: A probe starts by reading address 0. It keeps reading address 0 until two consecutive reads return the same byte, or until SETTLE_MAX reads have been made. In both cases it goes on to the command phase.
- R3: After the quiet phase the block writes 0xF0 to 0x555, then 0xAA to 0x555, then 0x55 to 0x2AA, then 0x90 to 0x555, in exactly that order. It then reads the manufacturer byte at address 0 and the device byte at address 1. No other bus writes occur in a probe except the one in R7.
- R4: Every access lasts ACC_CYC clocks with fl_addr_o and fl_wdata_o held steady. In a write, fl_we_o is high for the ACC_CYC-2 middle cycles only. In a read, fl_oe_o is high for all ACC_CYC cycles. fl_we_o and fl_oe_o are never high together.
- R5: If either ID byte has an even number of 1 bits, found_o is 0.
- R6: The key is {manufacturer, device}. The key matches only these entries, given as key/log2 device size/log2 sector size: 0x01A4/19/16, 0x01AD/21/16, 0x01D5/20/16, 0x013D/21/16, 0x20E3/19/16, 0xC2AD/21/16. Key 0 never matches. On a parity-clean match, found_o is 1 and the sizes are reported; otherwise both size outputs are 0.
- R7: Every probe, found or not, ends with a write of 0xF0 to 0x555. The device is left in array-read mode.
- R8: done_o is high for exactly one cycle at the end of a probe. The result outputs hold until the next accepted start, which clears them to 0.
- R9: A start pulse is ignored while busy_o is high, including the cycle in which done_o is high. It causes no extra bus access and does not change the results.
- R10: mfr_o and dev_o report the raw bytes that were read, even when found_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to begin a probe |
| fl_rdata_i | input | 8 | Read data from the flash |
| fl_addr_o | output | AW | Flash address |
| fl_wdata_o | output | 8 | Flash write data |
| fl_we_o | output | 1 | Write strobe, active high |
| fl_oe_o | output | 1 | Read strobe, active high |
| busy_o | output | 1 | Probe in progress |
| done_o | output | 1 | One-cycle end-of-probe pulse |
| found_o | output | 1 | Device recognised |
| mfr_o | output | 8 | Manufacturer byte read |
| dev_o | output | 8 | Device byte read |
| dev_size_log2_o | output | 5 | log2 of device size in bytes, 0 if not found |
| sect_size_log2_o | output | 5 | log2 of sector size in bytes, 0 if not found |

## Verification
Two events can land in the same cycle, and the bench provokes both.

The first is the quiet-phase exit. A consecutive-read match and the read-count limit can occur on the same read. The bench drives a flash model that toggles address 0 for a chosen number of reads. It sweeps that number across the limit, including the length where the match lands exactly on the last allowed read, and judges each case by how many reads of address 0 come before the first write.

The second is a start pulse that arrives in the same cycle as done_o. The bench drives it there and judges by the absence of any bus activity afterwards and by results that do not change.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  localparam int ID_TBL_DEPTH = 7;

  localparam logic [7:0] CMD_EXIT    = 8'hF0;
  localparam logic [7:0] CMD_UNLK_A  = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B  = 8'h55;
  localparam logic [7:0] CMD_ID_ENTR = 8'h90;

  localparam logic [31:0] ADR_CMD_A = 32'h555;
  localparam logic [31:0] ADR_CMD_B = 32'h2AA;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_CMD, ST_RD_MFR, ST_RD_DEV, ST_EVAL, ST_EXIT, ST_DONE
  } probe_state_e;

  typedef struct packed {
    logic       hit;
    logic [4:0] dev_log2;
    logic [4:0] sect_log2;
  } id_info_t;

  function automatic logic [15:0] tbl_key(input int i);
    case (i)
      0:       return 16'h01A4;
      1:       return 16'h01AD;
      2:       return 16'h01D5;
      3:       return 16'h013D;
      4:       return 16'h20E3;
      5:       return 16'hC2AD;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [4:0] tbl_dev_log2(input int i);
    case (i)
      0, 4:    return 5'd19;
      2:       return 5'd20;
      1, 3, 5: return 5'd21;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [4:0] tbl_sect_log2(input int i);
    return (tbl_key(i) != 16'h0) ? 5'd16 : 5'd0;
  endfunction

  // entry is reachable only if no zero key precedes it
  function automatic logic tbl_live(input int i);
    for (int j = 0; j < i; j++)
      if (tbl_key(j) == 16'h0) return 1'b0;
    return 1'b1;
  endfunction

endpackage

// File: rtl/flash_bus_port.sv
module flash_bus_port #(
  parameter int AW      = 12,
  parameter int ACC_CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic          ack_o,
  output logic [7:0]    rdata_o,
  input  logic [7:0]    fl_rdata_i,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_wdata_o,
  output logic          fl_we_o,
  output logic          fl_oe_o
);

  localparam int CW = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(ACC_CYC - 1);

  logic          active_q;
  logic          wr_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      wr_q     <= 1'b0;
      cnt_q    <= '0;
      addr_q   <= '0;
      wdata_q  <= '0;
      ack_o    <= 1'b0;
      rdata_o  <= '0;
    end else begin
      ack_o <= 1'b0;
      if (!active_q) begin
        if (req_i) begin
          active_q <= 1'b1;
          cnt_q    <= '0;
          wr_q     <= wr_i;
          addr_q   <= addr_i;
          wdata_q  <= wr_i ? wdata_i : 8'h00;
        end
      end else if (cnt_q == LAST) begin
        active_q <= 1'b0;
        ack_o    <= 1'b1;
        if (!wr_q) rdata_o <= fl_rdata_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign fl_addr_o  = addr_q;
  assign fl_wdata_o = wdata_q;
  // strobe only in the inner cycles so address/data frame it
  assign fl_we_o    = active_q && wr_q && (cnt_q != '0) && (cnt_q != LAST);
  assign fl_oe_o    = active_q && !wr_q;

endmodule

// File: rtl/flash_id_table.sv
module flash_id_table
  import flash_probe_pkg::*;
#(
  parameter int DEPTH = ID_TBL_DEPTH
) (
  input  logic [7:0] mfr_i,
  input  logic [7:0] dev_i,
  output id_info_t   info_o
);

  logic [DEPTH-1:0] match;
  logic             parity_ok;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
    assign match[gi] = tbl_live(gi) && (tbl_key(gi) != 16'h0) &&
                       (tbl_key(gi) == {mfr_i, dev_i});
  end

  assign parity_ok = (^mfr_i) && (^dev_i);

  always_comb begin
    info_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        info_o.dev_log2  = tbl_dev_log2(i);
        info_o.sect_log2 = tbl_sect_log2(i);
      end
    end
    info_o.hit = parity_ok && (|match);
    if (!info_o.hit) begin
      info_o.dev_log2  = '0;
      info_o.sect_log2 = '0;
    end
  end

endmodule

// File: rtl/flash_probe_seq.sv
module flash_probe_seq
  import flash_probe_pkg::*;
#(
  parameter int AW         = 12,
  parameter int SETTLE_MAX = 10000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          ack_i,
  input  logic [7:0]    rdata_i,
  output logic          req_o,
  output logic          wr_o,
  output logic [AW-1:0] addr_o,
  output logic [7:0]    wdata_o,
  output logic [7:0]    mfr_o,
  output logic [7:0]    dev_o,
  input  id_info_t      info_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          found_o,
  output logic [4:0]    dev_log2_o,
  output logic [4:0]    sect_log2_o
);

  localparam int SW = $clog2(SETTLE_MAX + 1);

  probe_state_e  state_q;
  logic          pend_q;
  logic [1:0]    cmd_idx_q;
  logic [SW-1:0] settle_cnt_q;
  logic          have_prev_q;
  logic [7:0]    prev_q;
  logic          settle_exit;

  always_comb begin
    wr_o    = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    req_o   = 1'b0;
    case (state_q)
      ST_SETTLE, ST_RD_MFR: req_o = !pend_q;
      ST_RD_DEV: begin
        req_o  = !pend_q;
        addr_o = AW'(1);
      end
      ST_CMD: begin
        req_o = !pend_q;
        wr_o  = 1'b1;
        case (cmd_idx_q)
          2'd0: begin addr_o = AW'(ADR_CMD_A); wdata_o = CMD_EXIT;    end
          2'd1: begin addr_o = AW'(ADR_CMD_A); wdata_o = CMD_UNLK_A;  end
          2'd2: begin addr_o = AW'(ADR_CMD_B); wdata_o = CMD_UNLK_B;  end
          default: begin addr_o = AW'(ADR_CMD_A); wdata_o = CMD_ID_ENTR; end
        endcase
      end
      ST_EXIT: begin
        req_o   = !pend_q;
        wr_o    = 1'b1;
        addr_o  = AW'(ADR_CMD_A);
        wdata_o = CMD_EXIT;
      end
      default: ;
    endcase
  end

  // match and read limit may coincide; either one ends the quiet phase
  assign settle_exit = (have_prev_q && (rdata_i == prev_q)) ||
                       (int'(settle_cnt_q) + 1 >= SETTLE_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      pend_q       <= 1'b0;
      cmd_idx_q    <= '0;
      settle_cnt_q <= '0;
      have_prev_q  <= 1'b0;
      prev_q       <= '0;
      mfr_o        <= '0;
      dev_o        <= '0;
      found_o      <= 1'b0;
      dev_log2_o   <= '0;
      sect_log2_o  <= '0;
    end else begin
      if (req_o) pend_q <= 1'b1;
      if (ack_i) pend_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q      <= ST_SETTLE;
          cmd_idx_q    <= '0;
          settle_cnt_q <= '0;
          have_prev_q  <= 1'b0;
          mfr_o        <= '0;
          dev_o        <= '0;
          found_o      <= 1'b0;
          dev_log2_o   <= '0;
          sect_log2_o  <= '0;
        end
        ST_SETTLE: if (ack_i) begin
          settle_cnt_q <= settle_cnt_q + 1'b1;
          prev_q       <= rdata_i;
          have_prev_q  <= 1'b1;
          if (settle_exit) state_q <= ST_CMD;
        end
        ST_CMD: if (ack_i) begin
          if (cmd_idx_q == 2'd3) state_q <= ST_RD_MFR;
          else cmd_idx_q <= cmd_idx_q + 1'b1;
        end
        ST_RD_MFR: if (ack_i) begin
          mfr_o   <= rdata_i;
          state_q <= ST_RD_DEV;
        end
        ST_RD_DEV: if (ack_i) begin
          dev_o   <= rdata_i;
          state_q <= ST_EVAL;
        end
        ST_EVAL: begin
          found_o     <= info_i.hit;
          dev_log2_o  <= info_i.dev_log2;
          sect_log2_o <= info_i.sect_log2;
          state_q     <= ST_EXIT;
        end
        ST_EXIT: if (ack_i) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_probe_pkg::*;
#(
  parameter int AW         = 12,
  parameter int ACC_CYC    = 4,
  parameter int SETTLE_MAX = 10000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    fl_rdata_i,
  output logic [AW-1:0] fl_addr_o,
  output logic [7:0]    fl_wdata_o,
  output logic          fl_we_o,
  output logic          fl_oe_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          found_o,
  output logic [7:0]    mfr_o,
  output logic [7:0]    dev_o,
  output logic [4:0]    dev_size_log2_o,
  output logic [4:0]    sect_size_log2_o
);

  logic          bus_req, bus_wr, bus_ack;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata, bus_rdata;
  id_info_t      info;

  flash_bus_port #(.AW(AW), .ACC_CYC(ACC_CYC)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (bus_req),
    .wr_i       (bus_wr),
    .addr_i     (bus_addr),
    .wdata_i    (bus_wdata),
    .ack_o      (bus_ack),
    .rdata_o    (bus_rdata),
    .fl_rdata_i (fl_rdata_i),
    .fl_addr_o  (fl_addr_o),
    .fl_wdata_o (fl_wdata_o),
    .fl_we_o    (fl_we_o),
    .fl_oe_o    (fl_oe_o)
  );

  flash_id_table #(.DEPTH(ID_TBL_DEPTH)) u_table (
    .mfr_i  (mfr_o),
    .dev_i  (dev_o),
    .info_o (info)
  );

  flash_probe_seq #(.AW(AW), .SETTLE_MAX(SETTLE_MAX)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .ack_i       (bus_ack),
    .rdata_i     (bus_rdata),
    .req_o       (bus_req),
    .wr_o        (bus_wr),
    .addr_o      (bus_addr),
    .wdata_o     (bus_wdata),
    .mfr_o       (mfr_o),
    .dev_o       (dev_o),
    .info_i      (info),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .found_o     (found_o),
    .dev_log2_o  (dev_size_log2_o),
    .sect_log2_o (sect_size_log2_o)
  );

endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk #(
  parameter int AW = 12
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] fl_addr_o,
  input logic [7:0]    fl_wdata_o,
  input logic          fl_we_o,
  input logic          fl_oe_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          found_o,
  input logic [7:0]    mfr_o,
  input logic [7:0]    dev_o,
  input logic [4:0]    dev_size_log2_o
);

  a_r4_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_we_o && fl_oe_o));

  a_r4_write_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_o |=> $stable(fl_addr_o) && $stable(fl_wdata_o));

  a_r3_cmd_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_we_o |-> (fl_wdata_o == 8'hF0 || fl_wdata_o == 8'hAA ||
                 fl_wdata_o == 8'h55 || fl_wdata_o == 8'h90));

  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r5_found_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> ((^mfr_o) && (^dev_o)));

  a_r6_size_on_miss: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !found_o |-> dev_size_log2_o == 5'd0);

  a_r9_busy_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  a_r8_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(found_o) && $stable(mfr_o) && $stable(dev_o));

endmodule

bind flash_id_probe flash_id_probe_chk #(.AW(AW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .start_i         (start_i),
  .fl_addr_o       (fl_addr_o),
  .fl_wdata_o      (fl_wdata_o),
  .fl_we_o         (fl_we_o),
  .fl_oe_o         (fl_oe_o),
  .busy_o          (busy_o),
  .done_o          (done_o),
  .found_o         (found_o),
  .mfr_o           (mfr_o),
  .dev_o           (dev_o),
  .dev_size_log2_o (dev_size_log2_o)
);

// File: tb/flash_id_probe_tb_top.sv
module flash_id_probe_tb_top;

  localparam int AW  = 12;
  localparam int ACC = 5;
  localparam int SMX = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [7:0]    fl_rdata;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_wdata;
  logic          fl_we, fl_oe, busy, done, found;
  logic [7:0]    mfr, dev;
  logic [4:0]    dsz, ssz;

  always #5 clk = ~clk;

  flash_id_probe #(.AW(AW), .ACC_CYC(ACC), .SETTLE_MAX(SMX)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .fl_rdata_i(fl_rdata),
    .fl_addr_o(fl_addr), .fl_wdata_o(fl_wdata), .fl_we_o(fl_we), .fl_oe_o(fl_oe),
    .busy_o(busy), .done_o(done), .found_o(found), .mfr_o(mfr), .dev_o(dev),
    .dev_size_log2_o(dsz), .sect_size_log2_o(ssz));

  // flash model
  logic [7:0] mdl_mfr = 8'h00, mdl_dev = 8'h00;
  int         tog_len = 0, rd0_base = 0;
  int         rd0_total = 0, wr_total = 0, oe_total = 0;
  logic [AW-1:0] wr_addr_log [16];
  logic [7:0]    wr_data_log [16];
  logic       id_mode = 1'b0;
  int         unlk = 0;
  logic       we_q = 1'b0, oe_q = 1'b0;
  int         we_run = 0, oe_run = 0, last_we_len = 0, last_oe_len = 0;

  always_comb begin
    int k;
    k = rd0_total - rd0_base + 1;
    if (id_mode)
      fl_rdata = (fl_addr == 0) ? mdl_mfr : (fl_addr == 1) ? mdl_dev : 8'h00;
    else if (fl_addr == 0)
      fl_rdata = (k <= tog_len) ? (k[0] ? 8'h11 : 8'h22) : 8'h33;
    else
      fl_rdata = 8'hFF;
  end

  always @(posedge clk) begin
    we_q <= fl_we;
    oe_q <= fl_oe;
    if (fl_we) we_run <= we_run + 1;
    else begin
      if (we_run != 0) last_we_len <= we_run;
      we_run <= 0;
    end
    if (fl_oe) oe_run <= oe_run + 1;
    else begin
      if (oe_run != 0) last_oe_len <= oe_run;
      oe_run <= 0;
    end
    if (oe_q && !fl_oe) begin
      oe_total <= oe_total + 1;
      if (!id_mode && fl_addr == 0) rd0_total <= rd0_total + 1;
    end
    if (fl_we && !we_q) begin
      wr_addr_log[wr_total % 16] <= fl_addr;
      wr_data_log[wr_total % 16] <= fl_wdata;
      wr_total <= wr_total + 1;
      if (fl_wdata == 8'hF0) begin id_mode <= 1'b0; unlk <= 0; end
      else if (unlk == 0 && fl_wdata == 8'hAA && fl_addr == 12'h555) unlk <= 1;
      else if (unlk == 1 && fl_wdata == 8'h55 && fl_addr == 12'h2AA) unlk <= 2;
      else if (unlk == 2 && fl_wdata == 8'h90 && fl_addr == 12'h555) begin
        id_mode <= 1'b1; unlk <= 0;
      end else unlk <= 0;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  function automatic bit odd8(input logic [7:0] v);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(v[i]);
    return (c % 2) == 1;
  endfunction

  // R6 table as stated in the requirement
  function automatic int exp_dev_log2(input logic [15:0] key);
    case (key)
      16'h01A4, 16'h20E3:           return 19;
      16'h01D5:                     return 20;
      16'h01AD, 16'h013D, 16'hC2AD: return 21;
      default:                      return 0;
    endcase
  endfunction

  task automatic run_probe(input logic [7:0] m, input logic [7:0] d,
                           input int tl, input int poke, input bit coll);
    int wb, cyc, exp_rd, edl;
    bit exp_found;
    logic [AW-1:0] ea [5];
    logic [7:0]    ed [5];
    ea = '{12'h555, 12'h555, 12'h2AA, 12'h555, 12'h555};
    ed = '{8'hF0, 8'hAA, 8'h55, 8'h90, 8'hF0};
    mdl_mfr = m; mdl_dev = d; tog_len = tl;
    rd0_base = rd0_total;
    wb = wr_total;
    exp_rd = (tl == 0) ? 2 : tl + 2;
    if (exp_rd > SMX) exp_rd = SMX;
    edl = exp_dev_log2({m, d});
    exp_found = odd8(m) && odd8(d) && (edl != 0);
    if (!exp_found) edl = 0;

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy === 1'b1, "R8", "busy after start", int'(busy), 1);
    chk(found === 1'b0 && mfr === 8'h00, "R8", "results cleared at start",
        int'({found, mfr}), 0);
    cyc = 0;
    while (done !== 1'b1 && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      start = (cyc == poke) ? 1'b1 : 1'b0;
    end
    start = 1'b0;
    chk(done === 1'b1, "R8", "done reached", int'(done), 1);
    chk(found === exp_found, "R5", "found", int'(found), int'(exp_found));
    chk(int'(dsz) == edl, "R6", "device size log2", int'(dsz), edl);
    chk(int'(ssz) == (exp_found ? 16 : 0), "R6", "sector size log2", int'(ssz),
        exp_found ? 16 : 0);
    chk(mfr === m && dev === d, "R10", "raw id bytes", int'({mfr, dev}), int'({m, d}));
    chk(wr_total - wb == 5, "R9", "write count", wr_total - wb, 5);
    for (int i = 0; i < 5; i++) begin
      chk(wr_addr_log[(wb + i) % 16] === ea[i] && wr_data_log[(wb + i) % 16] === ed[i],
          (i == 4) ? "R7" : "R3", "write sequence",
          int'({wr_addr_log[(wb + i) % 16], wr_data_log[(wb + i) % 16]}),
          int'({ea[i], ed[i]}));
    end
    chk(id_mode === 1'b0, "R7", "device left in read mode", int'(id_mode), 0);
    chk(rd0_total - rd0_base == exp_rd, "R2", "quiet-phase reads",
        rd0_total - rd0_base, exp_rd);
    chk(last_we_len == ACC - 2, "R4", "write strobe width", last_we_len, ACC - 2);
    chk(last_oe_len == ACC, "R4", "read strobe width", last_oe_len, ACC);
    if (coll) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done === 1'b0, "R8", "done one cycle", int'(done), 0);
    if (coll) begin
      wb = wr_total;
      cyc = oe_total;
      repeat (20) @(negedge clk);
      chk(busy === 1'b0 && wr_total == wb && oe_total == cyc && !fl_oe, "R9",
          "start with done ignored", wr_total - wb + oe_total - cyc, 0);
      chk(found === exp_found && mfr === m, "R8", "results held",
          int'({found, mfr}), int'({exp_found, m}));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog act=hung exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !found && !fl_we && !fl_oe && mfr == 0 && dev == 0 &&
        dsz == 0 && ssz == 0, "R1", "reset state",
        int'({busy, done, found, fl_we, fl_oe}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !fl_we && !fl_oe, "R1", "idle after reset", int'({busy, fl_we, fl_oe}), 0);

    for (int d = 0; d < 256; d++) run_probe(8'h01, 8'(d), 0, 0, 1'b0);
    for (int m = 0; m < 256; m++) run_probe(8'(m), 8'hAD, 1, 0, 1'b0);
    for (int t = 0; t <= 10; t++) run_probe(8'hC2, 8'hAD, t, 0, 1'b0);
    run_probe(8'h20, 8'hE3, 2, 12, 1'b0);
    run_probe(8'h20, 8'hE3, 0, 40, 1'b0);
    run_probe(8'h01, 8'hD5, 0, 0, 1'b1);
    run_probe(8'h02, 8'hD5, 3, 0, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule